// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps the time of day and the calendar date in packed BCD across eight 8-bit registers. A single-cycle tick enable at 100 Hz drives a carry chain. The chain runs from hundredths of a second through seconds, minutes and hours, then to the day of week and the date, and on to month and year. Month lengths follow the calendar, and February gains a 29th day in leap years. The hours register holds either a 24-hour count or a 12-hour count with a PM flag.

A host interface loads any register through a one-cycle write port and reads any register through a combinational read port. The day register carries two control flags. The first stops time from advancing. The second decides whether an external active-low reset input may request an abort of a host transfer. That request is driven on `abort_o`, and the calendar contents stay as they are.

Top module: `bcd_calendar_core`

## Requirements
- R1: After rst_ni is released the registers read: index 0 (hundredths) 8'h00, 1 (seconds) 8'h00, 2 (minutes) 8'h00, 3 (hours) 8'h00, 4 (day) 8'h31, 5 (date) 8'h01, 6 (month) 8'h01, 7 (year) 8'h00, and abort_o is 0.
- R2: When time is running, each tick_i increments hundredths in BCD from 00 to 99. Going from 99 to 00 carries into seconds. Seconds and minutes each count 00 to 59 and carry on wrap (09 goes to 10).
- R3: While day bit 5 is 1, tick_i has no effect on any register.
- R4: With hours bit 7 = 0 (24-hour mode), bits 5:4 hold the tens of hours and bits 3:0 the units. 23 wraps to 00 and carries into both the day and the date.
- R5: With hours bit 7 = 1 (12-hour mode), bit 5 is PM (1 = PM) and bits 4:0 hold BCD 01 to 12. The sequence 12 then 01 leaves PM unchanged. Going from 11 to 12 toggles PM, and carries into the day and date only when PM goes from 1 to 0.
- R6: Day bits 2:0 count 1 to 7 and wrap from 7 to 1 on an hours carry. Day bits 7:3 are unchanged by counting.
- R7: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other non-February months, carrying into the month. The month wraps from 12 to 01 and carries into the year, which wraps from 99 to 00.
- R8: In February the date wraps after 29 when the two-digit year is divisible by 4 (00 included), and after 28 otherwise.
- R9: Some bit positions always read 0 whatever is written: seconds bit 7, minutes bit 7, hours bit 6, day bits 7, 6 and 3, date bits 7:6, month bits 7:5.
- R10: A write (wr_en_i) replaces register wr_idx_i, and the new value is visible on the read port after the next clock edge. A tick_i in the same cycle as a write is dropped entirely.
- R11: abort_o is 1 exactly when ext_rst_ni is 0 and day bit 4 is 0. ext_rst_ni never alters a register.
- R12: rd_data_o combinationally shows register rd_idx_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 100 Hz advance enable, one cycle wide |
| ext_rst_ni | input | 1 | External abort request, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 3 | Register index to write |
| wr_data_i | input | 8 | Write data |
| rd_idx_i | input | 3 | Register index to read |
| rd_data_o | output | 8 | Read data for rd_idx_i |
| abort_o | output | 1 | Transfer abort request |

## Verification
The carry chain is driven from loaded end-of-period values. A single tick that lands on 31 Dec 99, 23:59:59.99 moves every register at once. Ticks that land mid-range only step the low digits, and the pair of cases shows whether each carry is gated by the stage below it. February is tried with years 23, 24 and 00, and 30-day months are set beside 31-day months, which separates the length table from the leap test. In 12-hour mode, starting points at 11 AM, 11 PM, 12 AM and 09 show whether PM toggles and whether a date carry happens on the right edge only. A write and a tick placed in the same cycle show that the write takes priority.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_REGS = 8;
  localparam int IDX_W    = $clog2(NUM_REGS);

  typedef logic [REG_W-1:0] reg_t;
  typedef logic [IDX_W-1:0] idx_t;

  localparam idx_t IDX_HUND  = 3'd0;
  localparam idx_t IDX_SEC   = 3'd1;
  localparam idx_t IDX_MIN   = 3'd2;
  localparam idx_t IDX_HOUR  = 3'd3;
  localparam idx_t IDX_DAY   = 3'd4;
  localparam idx_t IDX_DATE  = 3'd5;
  localparam idx_t IDX_MONTH = 3'd6;
  localparam idx_t IDX_YEAR  = 3'd7;

  localparam int DAY_STOP_BIT = 5;
  localparam int DAY_RIGN_BIT = 4;
  localparam int HOUR_12H_BIT = 7;
  localparam int HOUR_PM_BIT  = 5;

  // bits that may hold a 1
  function automatic reg_t keep_mask(input idx_t idx);
    case (idx)
      IDX_SEC, IDX_MIN: keep_mask = 8'h7F;
      IDX_HOUR:         keep_mask = 8'hBF;
      IDX_DAY:          keep_mask = 8'h37;
      IDX_DATE:         keep_mask = 8'h3F;
      IDX_MONTH:        keep_mask = 8'h1F;
      default:          keep_mask = 8'hFF;
    endcase
  endfunction

  function automatic reg_t reset_val(input idx_t idx);
    case (idx)
      IDX_DAY:              reset_val = 8'h31;
      IDX_DATE, IDX_MONTH:  reset_val = 8'h01;
      default:              reset_val = 8'h00;
    endcase
  endfunction

  function automatic reg_t step_lo(input idx_t idx);
    case (idx)
      IDX_DAY, IDX_DATE, IDX_MONTH: step_lo = 8'h01;
      default:                      step_lo = 8'h00;
    endcase
  endfunction

  function automatic reg_t step_hi(input idx_t idx);
    case (idx)
      IDX_SEC, IDX_MIN: step_hi = 8'h59;
      IDX_HOUR:         step_hi = 8'h23;
      IDX_DAY:          step_hi = 8'h07;
      IDX_DATE:         step_hi = 8'h31;
      IDX_MONTH:        step_hi = 8'h12;
      default:          step_hi = 8'h99;
    endcase
  endfunction

  function automatic reg_t bcd_inc(input reg_t v);
    if (v[3:0] >= 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'h0};
    else                bcd_inc = v + 8'd1;
  endfunction
endpackage

// File: rtl/bcd_wrap_cnt.sv
module bcd_wrap_cnt
  import bcd_cal_pkg::*;
(
  input  reg_t val_i,
  input  reg_t lo_i,
  input  reg_t hi_i,
  input  logic en_i,
  output reg_t nxt_o,
  output logic carry_o
);
  always_comb begin
    carry_o = 1'b0;
    nxt_o   = val_i;
    if (en_i) begin
      if (val_i >= hi_i) begin
        nxt_o   = lo_i;
        carry_o = 1'b1;
      end else begin
        nxt_o = bcd_inc(val_i);
      end
    end
  end
endmodule

// File: rtl/hour_step.sv
module hour_step
  import bcd_cal_pkg::*;
(
  input  reg_t hour_i,
  input  logic en_i,
  output reg_t nxt_o,
  output logic carry_o
);
  logic mode12, pm;
  reg_t v12, v24, inc12, inc24;

  assign mode12 = hour_i[HOUR_12H_BIT];
  assign pm     = hour_i[HOUR_PM_BIT];
  assign v12    = {3'b000, hour_i[4:0]};
  assign v24    = {1'b0, hour_i[6:0]};
  assign inc12  = bcd_inc(v12);
  assign inc24  = bcd_inc(v24);

  always_comb begin
    nxt_o   = hour_i;
    carry_o = 1'b0;
    if (en_i) begin
      if (mode12) begin
        if (v12 >= 8'h12) begin
          nxt_o = {1'b1, 1'b0, pm, 5'h01};
        end else if (v12 == 8'h11) begin
          nxt_o   = {1'b1, 1'b0, ~pm, 5'h12};
          carry_o = pm;  // 11 PM -> 12 AM
        end else begin
          nxt_o = {1'b1, 1'b0, pm, inc12[4:0]};
        end
      end else begin
        if (v24 >= 8'h23) begin
          nxt_o   = 8'h00;
          carry_o = 1'b1;
        end else begin
          nxt_o = {2'b00, inc24[5:0]};
        end
      end
    end
  end
endmodule

// File: rtl/month_limit.sv
module month_limit
  import bcd_cal_pkg::*;
(
  input  reg_t month_i,
  input  reg_t year_i,
  output reg_t last_o
);
  logic [6:0] yr_bin;
  logic       leap;

  assign yr_bin = 7'(year_i[7:4]) * 7'd10 + 7'(year_i[3:0]);
  assign leap   = (yr_bin[1:0] == 2'b00);

  always_comb begin
    case (month_i)
      8'h02:                      last_o = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
      default:                    last_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
  import bcd_cal_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ext_rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             abort_o
);
  localparam int FLAT_W = NUM_REGS * REG_W;

  reg_t q          [NUM_REGS];
  reg_t q_nxt      [NUM_REGS];
  reg_t step_val   [NUM_REGS];
  reg_t step_nxt   [NUM_REGS];
  logic step_en    [NUM_REGS];
  logic step_carry [NUM_REGS];
  reg_t last_date;
  logic run;
  logic [FLAT_W-1:0] time_q;

  assign run = tick_i & ~q[IDX_DAY][DAY_STOP_BIT];

  month_limit u_month_limit (
    .month_i (q[IDX_MONTH]),
    .year_i  (q[IDX_YEAR]),
    .last_o  (last_date)
  );

  // carry chain: day of week and date both step on hours carry
  always_comb begin
    step_en[IDX_HUND]  = run;
    step_en[IDX_SEC]   = step_carry[IDX_HUND];
    step_en[IDX_MIN]   = step_carry[IDX_SEC];
    step_en[IDX_HOUR]  = step_carry[IDX_MIN];
    step_en[IDX_DAY]   = step_carry[IDX_HOUR];
    step_en[IDX_DATE]  = step_carry[IDX_HOUR];
    step_en[IDX_MONTH] = step_carry[IDX_DATE];
    step_en[IDX_YEAR]  = step_carry[IDX_MONTH];
  end

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) step_val[i] = q[i];
    step_val[IDX_DAY] = q[IDX_DAY] & 8'h07;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_stage
    if (i == int'(IDX_HOUR)) begin : g_hour
      hour_step u_hour (
        .hour_i  (step_val[i]),
        .en_i    (step_en[i]),
        .nxt_o   (step_nxt[i]),
        .carry_o (step_carry[i])
      );
    end else begin : g_wrap
      bcd_wrap_cnt u_cnt (
        .val_i   (step_val[i]),
        .lo_i    (step_lo(IDX_W'(i))),
        .hi_i    ((i == int'(IDX_DATE)) ? last_date : step_hi(IDX_W'(i))),
        .en_i    (step_en[i]),
        .nxt_o   (step_nxt[i]),
        .carry_o (step_carry[i])
      );
    end
    assign time_q[i*REG_W +: REG_W] = q[i];
  end

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) q_nxt[i] = step_nxt[i];
    q_nxt[IDX_DAY] = (q[IDX_DAY] & 8'hF8) | (step_nxt[IDX_DAY] & 8'h07);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) q[i] <= reset_val(IDX_W'(i));
    end else if (wr_en_i) begin
      q[wr_idx_i] <= wr_data_i & keep_mask(wr_idx_i);
    end else if (run) begin
      for (int i = 0; i < NUM_REGS; i++) q[i] <= q_nxt[i];
    end
  end

  assign rd_data_o = q[rd_idx_i];
  assign abort_o   = ~ext_rst_ni & ~q[IDX_DAY][DAY_RIGN_BIT];
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk
  import bcd_cal_pkg::*;
(
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      tick_i,
  input logic                      wr_en_i,
  input logic [IDX_W-1:0]          wr_idx_i,
  input logic [REG_W-1:0]          wr_data_i,
  input logic                      abort_o,
  input logic [NUM_REGS*REG_W-1:0] time_i
);
  function automatic reg_t field(input logic [NUM_REGS*REG_W-1:0] t, input idx_t idx);
    field = t[idx*REG_W +: REG_W];
  endfunction

  logic stopped;
  reg_t hund, sec;
  assign stopped = time_i[IDX_DAY*REG_W + DAY_STOP_BIT];
  assign hund    = field(time_i, IDX_HUND);
  assign sec     = field(time_i, IDX_SEC);

  // R3
  osc_stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && stopped) |=> $stable(time_i));

  // R10
  wr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> field(time_i, $past(wr_idx_i)) == ($past(wr_data_i) & keep_mask($past(wr_idx_i))));

  // R2
  hund_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_en_i && !stopped && hund != 8'h99) |=> ($stable(sec) && !$stable(hund)));

  // R11
  rst_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_i[IDX_DAY*REG_W + DAY_RIGN_BIT] |-> !abort_o);

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_zero
    // R9
    zero_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (field(time_i, IDX_W'(k)) & ~keep_mask(IDX_W'(k))) == '0);
  end
endmodule

bind bcd_calendar_core bcd_calendar_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .wr_en_i   (wr_en_i),
  .wr_idx_i  (wr_idx_i),
  .wr_data_i (wr_data_i),
  .abort_o   (abort_o),
  .time_i    (time_q)
);

// File: tb/tb_bcd_calendar_core.sv
`timescale 1ns/1ps
module tb_bcd_calendar_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       ext_rst_n = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_idx = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_idx = '0;
  logic [7:0] rd_data;
  logic       abort;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bcd_calendar_core dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ext_rst_ni(ext_rst_n),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data), .abort_o(abort)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic chk_reg(input string tag, input int idx, input logic [7:0] exp);
    rd_idx = 3'(idx);
    #1;
    check(tag, rd_data, exp);
  endtask

  task automatic wr(input int idx, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic set_eod(input logic [7:0] hr);
    wr(0, 8'h99); wr(1, 8'h59); wr(2, 8'h59); wr(3, hr);
  endtask

  task automatic t_reset;
    logic [7:0] exp [8] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h31, 8'h01, 8'h01, 8'h00};
    for (int i = 0; i < 8; i++) chk_reg($sformatf("R1 R12 reset reg%0d", i), i, exp[i]);
    check("R1 abort at reset", {7'b0, abort}, 8'h00);
  endtask

  task automatic t_stop;
    ticks(5);
    chk_reg("R3 stopped after reset", 0, 8'h00);
    wr(4, 8'h21); wr(0, 8'h42);
    ticks(3);
    chk_reg("R3 stopped by write", 0, 8'h42);
    wr(4, 8'h01);
  endtask

  task automatic t_carry;
    wr(0, 8'h08); ticks(1);
    chk_reg("R2 hund step", 0, 8'h09);
    ticks(1);
    chk_reg("R2 hund tens", 0, 8'h10);
    chk_reg("R2 sec untouched", 1, 8'h00);
    wr(0, 8'h98); wr(1, 8'h59); wr(2, 8'h59); wr(3, 8'h23);
    wr(4, 8'h07); wr(5, 8'h31); wr(6, 8'h12); wr(7, 8'h99);
    ticks(1);
    chk_reg("R2 hund 99", 0, 8'h99);
    chk_reg("R2 sec hold", 1, 8'h59);
    ticks(1);
    chk_reg("R2 hund wrap", 0, 8'h00);
    chk_reg("R2 sec wrap", 1, 8'h00);
    chk_reg("R2 min wrap", 2, 8'h00);
    chk_reg("R4 hour 23->00", 3, 8'h00);
    chk_reg("R6 day 7->1", 4, 8'h01);
    chk_reg("R7 date 31->01", 5, 8'h01);
    chk_reg("R7 month 12->01", 6, 8'h01);
    chk_reg("R7 year 99->00", 7, 8'h00);
    wr(0, 8'h99); wr(1, 8'h09); ticks(1);
    chk_reg("R2 sec 09->10", 1, 8'h10);
  endtask

  task automatic t_month;
    wr(7, 8'h21); wr(6, 8'h04); wr(5, 8'h30); wr(4, 8'h03); set_eod(8'h23); ticks(1);
    chk_reg("R7 april date", 5, 8'h01);
    chk_reg("R7 april month", 6, 8'h05);
    chk_reg("R6 day 3->4", 4, 8'h04);
    wr(5, 8'h30); set_eod(8'h23); ticks(1);
    chk_reg("R7 may 30->31", 5, 8'h31);
    chk_reg("R7 may month hold", 6, 8'h05);
    wr(6, 8'h11); wr(5, 8'h30); set_eod(8'h23); ticks(1);
    chk_reg("R7 nov month", 6, 8'h12);
    set_eod(8'h22); ticks(1);
    chk_reg("R4 hour 22->23", 3, 8'h23);
    chk_reg("R4 no date carry", 5, 8'h01);
  endtask

  task automatic t_feb;
    wr(7, 8'h23); wr(6, 8'h02); wr(5, 8'h28); set_eod(8'h23); ticks(1);
    check_md("R8 year23", 8'h01, 8'h03);
    wr(7, 8'h24); wr(6, 8'h02); wr(5, 8'h28); set_eod(8'h23); ticks(1);
    check_md("R8 year24", 8'h29, 8'h02);
    set_eod(8'h23); ticks(1);
    check_md("R8 year24 end", 8'h01, 8'h03);
    wr(7, 8'h00); wr(6, 8'h02); wr(5, 8'h28); set_eod(8'h23); ticks(1);
    check_md("R8 year00", 8'h29, 8'h02);
  endtask

  task automatic check_md(input string tag, input logic [7:0] d, input logic [7:0] m);
    chk_reg({tag, " date"}, 5, d);
    chk_reg({tag, " month"}, 6, m);
  endtask

  task automatic t_12h;
    wr(6, 8'h05); wr(5, 8'h10);
    set_eod(8'h91); ticks(1);
    chk_reg("R5 11AM->12PM", 3, 8'hB2);
    chk_reg("R5 no date carry at noon", 5, 8'h10);
    set_eod(8'hB1); ticks(1);
    chk_reg("R5 11PM->12AM", 3, 8'h92);
    chk_reg("R5 date carry at midnight", 5, 8'h11);
    set_eod(8'h92); ticks(1);
    chk_reg("R5 12AM->01AM", 3, 8'h81);
    set_eod(8'hA9); ticks(1);
    chk_reg("R5 09PM->10PM", 3, 8'hB0);
  endtask

  task automatic t_zero;
    logic [7:0] exp [8] = '{8'hFF, 8'h7F, 8'h7F, 8'hBF, 8'h37, 8'h3F, 8'h1F, 8'hFF};
    for (int i = 1; i < 7; i++) begin
      wr(i, 8'hFF);
      chk_reg($sformatf("R9 zero bits reg%0d", i), i, exp[i]);
    end
    wr(4, 8'h01);
  endtask

  task automatic t_prio;
    wr(0, 8'h10);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd0; wr_data = 8'h50; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    chk_reg("R10 write beats tick", 0, 8'h50);
    ticks(1);
    chk_reg("R10 next tick counts", 0, 8'h51);
  endtask

  task automatic t_abort;
    wr(4, 8'h11);
    @(negedge clk); ext_rst_n = 1'b0; #1;
    check("R11 ignored when flag set", {7'b0, abort}, 8'h00);
    wr(4, 8'h01); #1;
    check("R11 abort when flag clear", {7'b0, abort}, 8'h01);
    chk_reg("R11 regs unchanged", 4, 8'h01);
    chk_reg("R11 hund unchanged", 0, 8'h51);
    @(negedge clk); ext_rst_n = 1'b1; #1;
    check("R11 abort released", {7'b0, abort}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_stop();
    t_carry();
    t_month();
    t_feb();
    t_12h();
    t_zero();
    t_prio();
    t_abort();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired got %0d exp 1", done);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule